// File: doc/BRIEF.md
# Programmable duty-cycle clock divider

This block divides a fast input clock by a counter. The high time and the low time of the output are each set on their own, in whole input-clock cycles. Any integer ratio from 2 to 32 is possible, and so are many duty cycles. The output comes from a flip-flop, so it has no glitches while the block is counting.

A chip-level synchronization strobe restarts the block, so several dividers can be aligned. Configuration selects several behaviours:

- the level the output starts at after a restart,
- a delay of some input cycles before the first phase begins,
- whether this block obeys the strobe at all,
- a static high output,
- a bypass in which the input clock passes straight through.

A `running` flag is high only while the counters are producing the divided waveform.

Top module: `clk_div_duty`

## Requirements
- R1: After synchronous reset with every configuration field at 0, the output starts low and `running` is 1. The block then divides by two with a 50% duty cycle: one cycle low, one cycle high.
- R2: The low phase lasts `cfg_low`+1 input cycles, where `cfg_low` is a 4-bit unsigned field. A value of 0 gives one cycle.
- R3: The high phase lasts `cfg_high`+1 input cycles, where `cfg_high` is a 4-bit unsigned field. A value of 0 gives one cycle.
- R4: A change to `cfg_low` or `cfg_high` never shortens or stretches the phase already in progress. The length of each phase is captured when that phase begins.
- R5: When `cfg_nosync`=0 and `sync_in`=1, the output is held at the start level on the next edge and `running` is 0. On the first edge that samples `sync_in`=0, a phase at the start level begins and lasts its programmed length.
- R6: A nonzero 4-bit `cfg_phase` value P, applied at the release of a sync, inserts P extra input cycles at the start level before the first phase begins. `running` stays 0 during those P cycles.
- R7: `cfg_start_high`=1 selects high as the start level, so the high phase comes first. A value of 0 selects low.
- R8: When `cfg_nosync`=1, `sync_in` has no effect on the output or on `running`.
- R9: When `cfg_nosync`=1 and `cfg_force_high`=1, the output is high from the next edge and `running` is 0. After `cfg_force_high` is cleared, counting resumes with a full high phase.
- R10: When `cfg_nosync`=0, `cfg_force_high` has no effect.
- R11: When `cfg_bypass`=1, `div_out` equals `clk_in` and `running` is 0. Bypass takes precedence over the static high and over sync. After bypass is cleared, a fresh phase at the start level begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Chip-level synchronization strobe |
| cfg_low | input | 4 | Low-phase length minus one |
| cfg_high | input | 4 | High-phase length minus one |
| cfg_phase | input | 4 | Start delay in input cycles, applied at sync release |
| cfg_start_high | input | 1 | Start level after sync: 1 high, 0 low |
| cfg_nosync | input | 1 | 1: ignore `sync_in` |
| cfg_bypass | input | 1 | 1: pass `clk_in` to the output |
| cfg_force_high | input | 1 | 1 with `cfg_nosync`=1: static high output |
| div_out | output | 1 | Divided clock |
| running | output | 1 | Counters are producing the waveform |

## Verification
The bench changes the count fields in the middle of long phases. A design that reads the fields live would cut a phase short or stretch it, and the per-cycle model would show the output toggling in the wrong cycle. The bench sweeps the phase offset from 1 up to its maximum of 15, which exposes an off-by-one delay count. It also sets the static-high bit both with and without the sync mask, so a block that forces high without checking `cfg_nosync` shows a high output where the model expects counting. Finally, it leaves bypass and the static-high mode in the middle of a phase, which shows whether the block restarts from the level the requirements define.

// File: rtl/clk_div_duty.sv
module clk_div_duty #(
  parameter int CW = 4
) (
  input  logic          clk_in,
  input  logic          rst,
  input  logic          sync_in,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_high,
  input  logic [CW-1:0] cfg_phase,
  input  logic          cfg_start_high,
  input  logic          cfg_nosync,
  input  logic          cfg_bypass,
  input  logic          cfg_force_high,
  output logic          div_out,
  output logic          running
);

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_HOLD = 2'd1, ST_DELAY = 2'd2} st_t;

  st_t           state;
  logic          out_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cur_len;

  wire static_on = cfg_nosync & cfg_force_high;
  wire sync_on   = sync_in & ~cfg_nosync;

  wire [CW-1:0] len_start = cfg_start_high ? cfg_high : cfg_low;
  wire [CW-1:0] len_held  = out_q ? cfg_high : cfg_low;
  wire [CW-1:0] len_flip  = out_q ? cfg_low : cfg_high;

  always_ff @(posedge clk_in) begin
    if (rst || cfg_bypass) begin
      state   <= ST_RUN;
      out_q   <= cfg_start_high;
      cnt     <= '0;
      cur_len <= len_start;
    end else if (static_on) begin
      state   <= ST_RUN;
      out_q   <= 1'b1;
      cnt     <= '0;
      cur_len <= cfg_high;
    end else if (sync_on) begin
      state   <= ST_HOLD;
      out_q   <= cfg_start_high;
      cnt     <= '0;
      cur_len <= len_start;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (cfg_phase == '0) begin
            state   <= ST_RUN;
            cnt     <= '0;
            cur_len <= len_held;
          end else begin
            state <= ST_DELAY;
            cnt   <= cfg_phase;
          end
        end
        ST_DELAY: begin
          if (cnt == CW'(1)) begin
            state   <= ST_RUN;
            cnt     <= '0;
            cur_len <= len_held;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == cur_len) begin
            out_q   <= ~out_q;
            cnt     <= '0;
            cur_len <= len_flip;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign div_out = cfg_bypass ? clk_in : out_q;
  assign running = (state == ST_RUN) & ~cfg_bypass & ~static_on;

endmodule

// File: rtl/clk_div_duty_chk.sv
module clk_div_duty_chk #(
  parameter int CW = 4
) (
  input logic          clk_in,
  input logic          rst,
  input logic          sync_in,
  input logic          cfg_start_high,
  input logic          cfg_nosync,
  input logic          cfg_bypass,
  input logic          cfg_force_high,
  input logic          div_out,
  input logic          running,
  input logic          out_q,
  input logic [1:0]    state,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cur_len
);

  a_r5_hold_level: assert property (@(posedge clk_in) disable iff (rst)
    (sync_in && !cfg_nosync && !cfg_bypass) |=> (out_q == $past(cfg_start_high)) && !running);

  a_r9_static_high: assert property (@(posedge clk_in) disable iff (rst)
    (cfg_nosync && cfg_force_high && !cfg_bypass) |=> out_q);

  a_r8_sync_masked: assert property (@(posedge clk_in) disable iff (rst)
    (running && cfg_nosync && !cfg_force_high && !cfg_bypass)
      |=> (running || cfg_bypass || (cfg_nosync && cfg_force_high)));

  a_r2_cnt_in_phase: assert property (@(posedge clk_in) disable iff (rst)
    (state == 2'd0) |-> (cnt <= cur_len));

  a_r4_phase_kept: assert property (@(posedge clk_in) disable iff (rst)
    (running && !(sync_in && !cfg_nosync) && cnt != cur_len)
      |=> ($stable(cur_len) && $stable(out_q)));

  always_comb begin
    if (!rst && cfg_bypass)
      a_r11_bypass_follow: assert (div_out == clk_in);
  end

endmodule

bind clk_div_duty clk_div_duty_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_clk_div_duty.sv
`timescale 1ns/1ps
module tb_clk_div_duty;

  logic       clk_in = 1'b0;
  logic       rst = 1'b1;
  logic       sync_in = 1'b0;
  logic [3:0] cfg_low = '0, cfg_high = '0, cfg_phase = '0;
  logic       cfg_start_high = 1'b0, cfg_nosync = 1'b0, cfg_bypass = 1'b0, cfg_force_high = 1'b0;
  logic       div_out, running;

  clk_div_duty dut (.*);

  always #5 clk_in = ~clk_in;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural reference: 0 counting, 1 held by sync, 2 offset delay
  int m_mode = 0;
  int m_lvl  = 0;
  int m_left = 1;
  int m_dly  = 0;

  function automatic int plen(int lvl);
    return (lvl != 0) ? int'(cfg_high) + 1 : int'(cfg_low) + 1;
  endfunction

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk_in);
    if (rst || cfg_bypass) begin
      m_mode = 0; m_lvl = cfg_start_high; m_left = plen(m_lvl);
    end else if (cfg_nosync && cfg_force_high) begin
      m_mode = 0; m_lvl = 1; m_left = plen(1);
    end else if (!cfg_nosync && sync_in) begin
      m_mode = 1; m_lvl = cfg_start_high;
    end else if (m_mode == 1) begin
      if (cfg_phase == 0) begin m_mode = 0; m_left = plen(m_lvl); end
      else begin m_mode = 2; m_dly = cfg_phase; end
    end else if (m_mode == 2) begin
      m_dly--;
      if (m_dly == 0) begin m_mode = 0; m_left = plen(m_lvl); end
    end else begin
      m_left--;
      if (m_left == 0) begin m_lvl = 1 - m_lvl; m_left = plen(m_lvl); end
    end
    #3;
    if (!done) begin
      check("div_out", div_out, cfg_bypass ? 1 : m_lvl);
      check("running", running, (m_mode == 0 && !cfg_bypass && !(cfg_nosync && cfg_force_high)) ? 1 : 0);
    end
  end

  always begin
    @(negedge clk_in);
    #1;
    if (!done && !rst && cfg_bypass) check("div_out low half (R11)", div_out, 0);
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_in);
  endtask

  task automatic pulse_sync(int n);
    sync_in = 1'b1; cyc(n); sync_in = 1'b0;
  endtask

  initial begin
    cyc(3); rst = 1'b0;
    tag = "R1"; cyc(12);
    tag = "R2"; cfg_low = 4'd3; cfg_high = 4'd1; cyc(30);
    tag = "R3"; cfg_low = 4'd0; cfg_high = 4'd5; cyc(25);
    tag = "R2"; cfg_low = 4'd15; cfg_high = 4'd15; cyc(70);
    tag = "R4"; cfg_low = 4'd9; cfg_high = 4'd9; cyc(13);
    cfg_low = 4'd1; cfg_high = 4'd2; cyc(4); cfg_high = 4'd7; cyc(30);
    tag = "R5"; cfg_low = 4'd2; cfg_high = 4'd3; pulse_sync(4); cyc(20);
    tag = "R6"; cfg_phase = 4'd5; pulse_sync(2); cyc(25);
    cfg_phase = 4'd15; pulse_sync(1); cyc(35);
    cfg_phase = 4'd1; pulse_sync(3); cyc(12);
    tag = "R5"; cfg_phase = 4'd12; pulse_sync(1); cyc(6); pulse_sync(2); cyc(30);
    cfg_phase = 4'd0;
    tag = "R7"; cfg_start_high = 1'b1; pulse_sync(2); cyc(20);
    cfg_start_high = 1'b0;
    tag = "R8"; cfg_nosync = 1'b1; cyc(3); pulse_sync(3); cyc(5); pulse_sync(1); cyc(15);
    tag = "R9"; cfg_force_high = 1'b1; cyc(6); pulse_sync(2); cyc(4); cfg_force_high = 1'b0; cyc(20);
    tag = "R10"; cfg_nosync = 1'b0; cfg_force_high = 1'b1; cyc(20); pulse_sync(2); cyc(15);
    cfg_force_high = 1'b0;
    tag = "R11"; cyc(2); cfg_bypass = 1'b1; cyc(8); pulse_sync(2); cfg_force_high = 1'b1; cfg_nosync = 1'b1; cyc(4);
    cfg_force_high = 1'b0; cfg_nosync = 1'b0; cfg_start_high = 1'b1; cyc(3); cfg_bypass = 1'b0; cyc(20);
    tag = "R4";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 11) == 0) cfg_low = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 11) == 0) cfg_high = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 39) == 0) cfg_phase = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 59) == 0) cfg_start_high = ~cfg_start_high;
      if ($urandom_range(0, 79) == 0) cfg_nosync = ~cfg_nosync;
      if ($urandom_range(0, 99) == 0) cfg_force_high = ~cfg_force_high;
      cfg_bypass = ($urandom_range(0, 149) == 0) ? ~cfg_bypass : cfg_bypass;
      sync_in = ($urandom_range(0, 29) == 0);
      cyc(1);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL %s watchdog: actual 0 expected 1 (run completed)", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule